// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked system read and write an external 256K x 8 asynchronous static RAM. The system side offers single-beat requests on a valid/ready handshake, each carrying a direction bit, an 18-bit word address and, for writes, a byte of data. The memory side drives a pair of chip selects of opposite polarity, an active-low write strobe, an active-low output enable and the address lines. The shared data bus is presented as a split output, enable and input triple, so the pad ring can build the tri-state buffer.

Every timing window of the memory is given as a nanosecond parameter and converted to whole clock cycles, always rounded up. A write holds the strobe low for the longest of the strobe-width, address-to-strobe-end and data-setup windows, and then waits out any remaining write-cycle time. A read keeps the output enable low for the longest of the read-cycle, address-access and output-enable-access windows. It samples the bus on the last edge of that window and raises a one-cycle valid pulse. After a read the controller idles for the output-float time, so that the next request cannot drive the bus while the memory is still releasing it.

Top module: `sram_port_ctrl`

## Requirements
- R1: After reset, and whenever the controller is idle, the active-low select is 1, the active-high select is 0, the write strobe and the output enable are both 1 (inactive), the bus driver enable is 0, the request ready is 1 and the read valid is 0.
- R2: The two selects always carry opposite levels, so the memory is selected exactly when the active-low select is 0.
- R3: A write accepted on a clock edge turns on the select, the low write strobe and the bus driver in the next cycle. All three stay on for the write-pulse count, which is 5 cycles with the default 10 ns clock. The output enable stays 1 throughout, and the bus carries the request data.
- R4: While the memory is selected, the address lines hold the request address and do not change.
- R5: A write keeps ready low for the full write-cycle count, 6 cycles by default, after the accepting edge. This includes any recovery cycle after the strobe rises.
- R6: A read accepted on a clock edge turns on the select and pulls the output enable to 0, with the write strobe at 1 and the bus driver off. This holds for the read-window count, 6 cycles by default.
- R7: The bus is sampled on the clock edge that ends the read window. The read valid is 1 for exactly one cycle, the first cycle after the window, and the read data then holds the sampled byte.
- R8: After a read window the controller stays busy for the output-float count, 2 cycles by default, so ready returns 8 cycles after the accepting edge.
- R9: The bus driver is never on while the output enable is 0.
- R10: Bytes written to different addresses, including address 0 and the highest address, are read back unchanged, and a later write to the same address replaces the earlier byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle pulse, read data valid |
| rd_data | output | 8 | Byte returned by the last read |
| mem_addr | output | 18 | Address lines to the memory |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Data driven onto the bus |
| mem_dq_oe | output | 1 | Bus driver enable |
| mem_dq_in | input | 8 | Data seen on the bus |

## Verification
The assertions take for granted that the memory drives the bus only while it is selected with the output enable low. They also rely on the request fields being taken only on the edge where both valid and ready are high, so a change to them at any other time is ignored. The bench memory model follows the first rule: it returns the stored byte only after the read has been held open for the full access count, and a known wrong byte before that. The bench drives requests only on falling edges while ready is high and drops them after the accepting edge, so the handshake stays within the second rule.

// File: rtl/sram_port_pkg.sv
package sram_port_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_PULSE,
        ST_WR_RECOV,
        ST_RD_ACCESS,
        ST_RD_TURN
    } seq_state_e;

    // nanoseconds to clock cycles, rounded up
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_read_capture.sv
module sram_read_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d       = cap_q;
        cap_d.valid = capture;
        if (capture) begin
            cap_d.data = dq_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign rd_data  = cap_q.data;
    assign rd_valid = cap_q.valid;

    AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R7

endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
    import sram_port_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 8,
    parameter int CLK_NS = 10,
    parameter int T_WC   = 55,  // write cycle
    parameter int T_WP   = 45,  // strobe width
    parameter int T_AW   = 50,  // address valid to strobe end
    parameter int T_DW   = 25,  // data setup to strobe end
    parameter int T_RC   = 55,  // read cycle
    parameter int T_AA   = 55,  // address access
    parameter int T_OE   = 30,  // output enable access
    parameter int T_HZ   = 20   // output float
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int unsigned WP_CYC  = max2(1, max2(ns_to_cyc(T_WP, CLK_NS),
                                      max2(ns_to_cyc(T_AW, CLK_NS), ns_to_cyc(T_DW, CLK_NS))));
    localparam int unsigned WC_CYC  = ns_to_cyc(T_WC, CLK_NS);
    localparam int unsigned REC_CYC = (WC_CYC > WP_CYC) ? (WC_CYC - WP_CYC) : 0;
    localparam int unsigned RA_CYC  = max2(1, max2(ns_to_cyc(T_RC, CLK_NS),
                                      max2(ns_to_cyc(T_AA, CLK_NS), ns_to_cyc(T_OE, CLK_NS))));
    localparam int unsigned HZ_CYC  = ns_to_cyc(T_HZ, CLK_NS);
    localparam int unsigned MAX_LD  = max2(max2(WP_CYC, RA_CYC), max2(REC_CYC, HZ_CYC));
    localparam int          CNT_W   = $clog2(MAX_LD + 1);

    typedef struct packed {
        seq_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              sel_n;
        logic              sel;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{
        state: ST_IDLE, addr: '0, wdata: '0,
        sel_n: 1'b1, sel: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0
    };

    ctl_t             ctl_d, ctl_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             cap_en;

    always_comb begin
        ctl_d    = ctl_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cap_en   = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.addr  = req_addr;
                    ctl_d.sel_n = 1'b0;
                    ctl_d.sel   = 1'b1;
                    tmr_load    = 1'b1;
                    if (req_write) begin
                        // strobe falls with the select: memory never drives
                        ctl_d.state = ST_WR_PULSE;
                        ctl_d.wdata = req_wdata;
                        ctl_d.we_n  = 1'b0;
                        ctl_d.dq_oe = 1'b1;
                        tmr_val     = CNT_W'(WP_CYC - 1);
                    end else begin
                        ctl_d.state = ST_RD_ACCESS;
                        ctl_d.oe_n  = 1'b0;
                        tmr_val     = CNT_W'(RA_CYC - 1);
                    end
                end
            end
            ST_WR_PULSE: begin
                if (tmr_zero) begin
                    ctl_d.sel_n = 1'b1;
                    ctl_d.sel   = 1'b0;
                    ctl_d.we_n  = 1'b1;
                    ctl_d.dq_oe = 1'b0;
                    if (REC_CYC > 0) begin
                        ctl_d.state = ST_WR_RECOV;
                        tmr_load    = 1'b1;
                        tmr_val     = CNT_W'(REC_CYC - 1);
                    end else begin
                        ctl_d.state = ST_IDLE;
                    end
                end
            end
            ST_WR_RECOV: begin
                if (tmr_zero) begin
                    ctl_d.state = ST_IDLE;
                end
            end
            ST_RD_ACCESS: begin
                if (tmr_zero) begin
                    cap_en      = 1'b1;
                    ctl_d.sel_n = 1'b1;
                    ctl_d.sel   = 1'b0;
                    ctl_d.oe_n  = 1'b1;
                    if (HZ_CYC > 0) begin
                        ctl_d.state = ST_RD_TURN;
                        tmr_load    = 1'b1;
                        tmr_val     = CNT_W'(HZ_CYC - 1);
                    end else begin
                        ctl_d.state = ST_IDLE;
                    end
                end
            end
            ST_RD_TURN: begin
                if (tmr_zero) begin
                    ctl_d.state = ST_IDLE;
                end
            end
            default: ctl_d = CTL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    sram_wait_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    sram_read_capture #(
        .DATA_W (DATA_W)
    ) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (cap_en),
        .dq_in    (mem_dq_in),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    assign req_ready  = (ctl_q.state == ST_IDLE);
    assign mem_addr   = ctl_q.addr;
    assign mem_sel_n  = ctl_q.sel_n;
    assign mem_sel    = ctl_q.sel;
    assign mem_we_n   = ctl_q.we_n;
    assign mem_oe_n   = ctl_q.oe_n;
    assign mem_dq_out = ctl_q.wdata;
    assign mem_dq_oe  = ctl_q.dq_oe;

    AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_sel_n && !mem_sel && mem_we_n && mem_oe_n && !mem_dq_oe && !rd_valid)); // R1

    AST_SEL_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel_n != mem_sel); // R2

    AST_STROBE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_dq_oe && !mem_sel_n && mem_oe_n)); // R3

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_sel_n && $past(!mem_sel_n)) |-> $stable(mem_addr)); // R4

    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe && !mem_oe_n)); // R9

    AST_READ_STROBE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_sel_n)); // R6

endmodule

// File: tb/sram_port_ctrl_tb.sv
module sram_port_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int EXP_WP = 5;   // max(45,50,25)/10 rounded up
    localparam int EXP_WC = 6;   // 55/10 rounded up
    localparam int EXP_RA = 6;   // max(55,55,30)/10 rounded up
    localparam int EXP_HZ = 2;   // 20/10

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [17:0] mem_addr;
    logic        mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_port_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .mem_addr   (mem_addr),
        .mem_sel_n  (mem_sel_n),
        .mem_sel    (mem_sel),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .mem_dq_in  (mem_dq_in)
    );

    // memory model and pin monitors, sampled mid-cycle
    logic [7:0]  store [int];
    logic        wov_prev = 1'b0;
    logic [17:0] wa_prev = '0;
    logic [7:0]  wd_prev = '0;
    logic        sel_prev = 1'b0;
    logic [17:0] addr_prev = '0;
    int          rd_cnt = 0;
    logic [7:0]  rd_word = '0;
    int          sel_err = 0;
    int          cont_err = 0;
    int          addr_err = 0;

    assign mem_dq_in = (rd_cnt >= EXP_RA) ? rd_word : 8'hEE;

    always @(negedge clk) begin
        logic sel_now, wov_now;
        sel_now = !mem_sel_n && mem_sel;
        wov_now = sel_now && !mem_we_n;
        if (wov_prev && !wov_now) store[int'(wa_prev)] = wd_prev;
        wov_prev = wov_now;
        wa_prev  = mem_addr;
        wd_prev  = mem_dq_out;
        if (sel_now && !mem_oe_n && mem_we_n) begin
            rd_cnt++;
            rd_word = store.exists(int'(mem_addr)) ? store[int'(mem_addr)] : 8'h00;
        end else begin
            rd_cnt = 0;
        end
        if (rst_n) begin
            if (mem_sel_n == mem_sel) sel_err++;
            if (mem_dq_oe && !mem_oe_n) cont_err++;
            if (sel_now && sel_prev && mem_addr != addr_prev) addr_err++;
        end
        sel_prev  = sel_now;
        addr_prev = mem_addr;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic wr, input logic [17:0] a, input logic [7:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_wdata = ~d;
        req_addr  = ~a;
    endtask

    task automatic do_write(input logic [17:0] a, input logic [7:0] d);
        int we_cnt = 0, oe_cnt = 0, drv_cnt = 0, busy = 0, data_bad = 0, addr_bad = 0;
        int first_we = 0;
        issue(1'b1, a, d);
        for (int i = 1; i < 40; i++) begin
            if (req_ready) break;
            busy++;
            if (!mem_we_n) begin
                we_cnt++;
                if (first_we == 0) first_we = i;
                if (mem_dq_out != d) data_bad++;
            end
            if (!mem_sel_n && mem_addr != a) addr_bad++;
            if (!mem_oe_n) oe_cnt++;
            if (mem_dq_oe) drv_cnt++;
            @(negedge clk);
        end
        chk("R3", "strobe low cycles", we_cnt, EXP_WP);
        chk("R3", "strobe falls in first cycle", first_we, 1);
        chk("R3", "driver on cycles", drv_cnt, EXP_WP);
        chk("R3", "output enable low during write", oe_cnt, 0);
        chk("R3", "bus data mismatches", data_bad, 0);
        chk("R4", "write address mismatches", addr_bad, 0);
        chk("R5", "write busy cycles", busy, EXP_WC);
    endtask

    task automatic do_read(input logic [17:0] a, input logic [7:0] exp_d);
        int oe_cnt = 0, sel_cnt = 0, drv_cnt = 0, busy = 0, we_low = 0, addr_bad = 0;
        int v_cnt = 0, v_at = 0;
        logic [7:0] got = '0;
        issue(1'b0, a, 8'h00);
        for (int i = 1; i < 40; i++) begin
            if (req_ready) break;
            busy++;
            if (!mem_oe_n) oe_cnt++;
            if (!mem_sel_n) begin
                sel_cnt++;
                if (mem_addr != a) addr_bad++;
            end
            if (mem_dq_oe) drv_cnt++;
            if (!mem_we_n) we_low++;
            if (rd_valid) begin
                v_cnt++;
                v_at = i;
                got  = rd_data;
            end
            @(negedge clk);
        end
        if (rd_valid) v_cnt++;
        chk("R6", "output enable low cycles", oe_cnt, EXP_RA);
        chk("R6", "select cycles", sel_cnt, EXP_RA);
        chk("R6", "driver on during read", drv_cnt, 0);
        chk("R6", "strobe low during read", we_low, 0);
        chk("R4", "read address mismatches", addr_bad, 0);
        chk("R7", "valid pulse count", v_cnt, 1);
        chk("R7", "valid pulse cycle", v_at, EXP_RA + 1);
        chk("R7", "read data", int'(got), int'(exp_d));
        chk("R7", "read data held", int'(rd_data), int'(exp_d));
        chk("R8", "read busy cycles", busy, EXP_RA + EXP_HZ);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1", "select n", int'(mem_sel_n), 1);
        chk("R1", "select", int'(mem_sel), 0);
        chk("R1", "write strobe", int'(mem_we_n), 1);
        chk("R1", "output enable", int'(mem_oe_n), 1);
        chk("R1", "driver", int'(mem_dq_oe), 0);
        chk("R1", "ready", int'(req_ready), 1);
        chk("R1", "read valid", int'(rd_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "ready after release", int'(req_ready), 1);
        chk("R1", "select n after release", int'(mem_sel_n), 1);
    endtask

    task automatic t_basic();
        do_write(18'h00123, 8'h5A);
        do_read(18'h00123, 8'h5A);
    endtask

    task automatic t_boundaries();
        do_write(18'h00000, 8'hA5);
        do_write(18'h3FFFF, 8'h3C);
        do_write(18'h15555, 8'hFF);
        do_write(18'h2AAAA, 8'h00);
        do_read(18'h00000, 8'hA5);   // R10
        do_read(18'h3FFFF, 8'h3C);   // R10
        do_read(18'h15555, 8'hFF);   // R10
        do_read(18'h2AAAA, 8'h00);   // R10
        chk("R10", "stored low word", int'(store[0]), 8'hA5);
    endtask

    task automatic t_overwrite();
        do_write(18'h01000, 8'h11);
        do_write(18'h01000, 8'h96);
        do_read(18'h01000, 8'h96);   // R10
        do_read(18'h01000, 8'h96);   // R10 back-to-back reads
        do_write(18'h01001, 8'h69);
        do_read(18'h01000, 8'h96);   // R10 neighbour unaffected
    endtask

    task automatic t_monitors();
        chk("R2", "select pair violations", sel_err, 0);
        chk("R9", "bus contention cycles", cont_err, 0);
        chk("R4", "address change while selected", addr_err, 0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_boundaries();
        t_overwrite();
        t_monitors();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule